// File: doc/BRIEF.md
# Selectable-Phase PWM Start Sequencer

This block issues the start-of-cycle trigger pulses for a multiphase switching controller with up to six phases. A free-running counter measures out one switching period, and each active phase receives exactly one single-cycle trigger per period. The triggers are spread evenly across the period, so the spacing follows from how many phases are in use.

Phases are removed through six disable inputs. Only a few disable sets are legal, and each one has its own fixed firing order with particular phase numbers skipped. The disable set and the period length are captured when the enable input rises. They then stay fixed until enable drops and rises again. An illegal disable set raises an error output and suppresses all triggers.

Top module: `phase_sequencer`

## Requirements
- R1: After a synchronous active-low reset, `trig` is all zero, `active_cnt` is 0 and `cfg_err` is 0.
- R2: With `phase_off` = 6'b000000 (bit i disables phase i+1), six phases fire in the order 1,2,3,4,5,6. Slot k fires at count floor(k*P/6), where P is the latched period and `trig` bit i stands for phase i+1.
- R3: With `phase_off` = 6'b000100 (phase 3 off), five phases fire in the order 1,2,4,5,6 at counts floor(k*P/5).
- R4: With `phase_off` = 6'b100000 (phase 6 off), five phases fire in the order 1,2,3,4,5 at counts floor(k*P/5).
- R5: With `phase_off` = 6'b100100 (phases 3 and 6 off), four phases fire in the order 1,2,4,5 at counts floor(k*P/4).
- R6: With `phase_off` = 6'b010101 (phases 1, 3 and 5 off), three phases fire in the order 2,4,6 at counts floor(k*P/3).
- R7: `phase_off` and `period` are captured on the clock edge where `en` is first seen high. Changing either input while enabled has no effect, and a disabled phase never pulses.
- R8: Any other `phase_off` pattern sets `cfg_err` to 1 and `active_cnt` to 0, and no trigger pulse is produced while enabled.
- R9: Every trigger is one clock wide, at most one `trig` bit is high in any cycle, and the pattern repeats every P cycles. The first slot shows on the first cycle after the capturing edge (count 0). P must be at least 6.
- R10: When `en` is seen low at a clock edge, triggers stop from that edge and the counter returns to 0. A later re-enable starts again at count 0.
- R11: `active_cnt` gives the number of phases in the captured legal set (6, 5, 4 or 3). It holds its value after `en` drops, until the next capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run enable; its rising edge captures the configuration |
| period | input | PER_W | Switching period in clock cycles (at least 6) |
| phase_off | input | 6 | Per-phase disable flags, bit i for phase i+1 |
| trig | output | 6 | One-cycle start pulse per phase, bit i for phase i+1 |
| active_cnt | output | 3 | Number of active phases in the captured set, 0 on error |
| cfg_err | output | 1 | Captured disable set is not legal |

## Verification
The checker watches every cycle for properties that hold in any mode. These are: at most one trigger at a time, no trigger from a phase that was disabled at capture, no trigger during an error or in the cycle after `en` is seen low, no phase held high for two cycles, and `active_cnt` staying among its legal values. Firing order, slot timing for each legal set, the floor rounding of slot positions, the ignoring of input changes during a run, and the restart from count zero can only be shown by the bench scenarios. These scenarios compare each observed pulse against a cycle-exact list of expected pulses.

// File: rtl/phase_seq_pkg.sv
// Shared constants and types for the phase start sequencer.
// Assumes at most six phases; phase indices are zero-based internally.
package phase_seq_pkg;
    localparam int NPH   = 6;
    localparam int IDX_W = 3;

    typedef logic [IDX_W-1:0] phase_idx_t;

    typedef enum logic [2:0] {
        MODE_SIX,
        MODE_FIVE_NO3,
        MODE_FIVE_NO6,
        MODE_FOUR,
        MODE_THREE,
        MODE_BAD
    } seq_mode_e;
endpackage

// File: rtl/phase_mode_decoder.sv
// Decodes the six disable flags into a legal mode, the active phase count
// and the firing order (slot -> phase index). Purely combinational.
// Assumes flag bit i disables phase i+1; unused slots carry index 0.
module phase_mode_decoder
    import phase_seq_pkg::*;
(
    input  logic [NPH-1:0]              off_flags,
    output logic [2:0]                  num_active,
    output logic                        bad_set,
    output logic [NPH-1:0][IDX_W-1:0]   slot_phase
);
    seq_mode_e mode;

    // Classify the flag pattern into one of the legal sets.
    always_comb begin
        case (off_flags)
            6'b000000: mode = MODE_SIX;
            6'b000100: mode = MODE_FIVE_NO3;
            6'b100000: mode = MODE_FIVE_NO6;
            6'b100100: mode = MODE_FOUR;
            6'b010101: mode = MODE_THREE;
            default:   mode = MODE_BAD;
        endcase
    end

    // Produce count, error flag and firing order for the chosen mode.
    always_comb begin
        slot_phase = '0;
        bad_set    = 1'b0;
        num_active = 3'd0;
        case (mode)
            MODE_SIX: begin
                num_active = 3'd6;
                for (int s = 0; s < NPH; s++) slot_phase[s] = IDX_W'(s);
            end
            MODE_FIVE_NO3: begin
                num_active    = 3'd5;
                slot_phase[0] = 3'd0;
                slot_phase[1] = 3'd1;
                slot_phase[2] = 3'd3;
                slot_phase[3] = 3'd4;
                slot_phase[4] = 3'd5;
            end
            MODE_FIVE_NO6: begin
                num_active = 3'd5;
                for (int s = 0; s < 5; s++) slot_phase[s] = IDX_W'(s);
            end
            MODE_FOUR: begin
                num_active    = 3'd4;
                slot_phase[0] = 3'd0;
                slot_phase[1] = 3'd1;
                slot_phase[2] = 3'd3;
                slot_phase[3] = 3'd4;
            end
            MODE_THREE: begin
                num_active    = 3'd3;
                slot_phase[0] = 3'd1;
                slot_phase[1] = 3'd3;
                slot_phase[2] = 3'd5;
            end
            default: bad_set = 1'b1;
        endcase
    end
endmodule

// File: rtl/phase_slot_timer.sv
// Computes the count value of every slot: floor(k * period / n) for
// k < n, where n is 3..6. Combinational; division by constants only.
// Assumes the result is below period, so it fits in PER_W bits.
module phase_slot_timer
    import phase_seq_pkg::*;
#(
    parameter int PER_W = 16
) (
    input  logic [PER_W-1:0]            period,
    input  logic [2:0]                  num_active,
    output logic [NPH-1:0][PER_W-1:0]   slot_time
);
    localparam int PW = PER_W + 3;

    for (genvar k = 0; k < NPH; k++) begin : g_slot
        localparam logic [PW-1:0] KW = PW'(k);
        logic [PW-1:0] prod;

        assign prod = KW * PW'(period);

        // Divide the slot product by the active count.
        always_comb begin
            case (num_active)
                3'd3:    slot_time[k] = PER_W'(prod / PW'(3));
                3'd4:    slot_time[k] = PER_W'(prod / PW'(4));
                3'd5:    slot_time[k] = PER_W'(prod / PW'(5));
                3'd6:    slot_time[k] = PER_W'(prod / PW'(6));
                default: slot_time[k] = '0;
            endcase
        end
    end
endmodule

// File: rtl/phase_period_counter.sv
// Free-running period counter: clears on start or when not running,
// otherwise counts 0..limit-1 and wraps. Assumes limit >= 1.
module phase_period_counter #(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             start,
    input  logic [PER_W-1:0] limit,
    output logic [PER_W-1:0] count
);
    // Advance, wrap or clear the period count.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || start) begin
            count <= '0;
        end else if (count == limit - PER_W'(1)) begin
            count <= '0;
        end else begin
            count <= count + PER_W'(1);
        end
    end
endmodule

// File: rtl/phase_sequencer.sv
// Top of the phase start sequencer. On the rising edge of en it captures
// the disable flags, period, firing order and slot times, then emits one
// single-cycle trigger per active phase per period. Assumes period >= 6.
module phase_sequencer
    import phase_seq_pkg::*;
#(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [PER_W-1:0] period,
    input  logic [5:0]       phase_off,
    output logic [5:0]       trig,
    output logic [2:0]       active_cnt,
    output logic             cfg_err
);
    logic                            run_q;
    logic                            start;
    logic [NPH-1:0]                  mask_q;
    logic [PER_W-1:0]                period_q;
    logic [2:0]                      count_q;
    logic                            err_q;
    logic [NPH-1:0][IDX_W-1:0]       order_q;
    logic [NPH-1:0][PER_W-1:0]       times_q;
    logic [PER_W-1:0]                cnt;
    logic [NPH-1:0]                  slot_hit;

    logic [2:0]                      dec_count;
    logic                            dec_bad;
    logic [NPH-1:0][IDX_W-1:0]       dec_order;
    logic [NPH-1:0][PER_W-1:0]       dec_times;

    assign start = en && !run_q;

    phase_mode_decoder u_dec (
        .off_flags  (phase_off),
        .num_active (dec_count),
        .bad_set    (dec_bad),
        .slot_phase (dec_order)
    );

    phase_slot_timer #(.PER_W(PER_W)) u_time (
        .period     (period),
        .num_active (dec_count),
        .slot_time  (dec_times)
    );

    phase_period_counter #(.PER_W(PER_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (en),
        .start (start),
        .limit (period_q),
        .count (cnt)
    );

    // Track the running state from the sampled enable.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= en;
    end

    // Capture the configuration once per enable rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q   <= '0;
            period_q <= PER_W'(NPH);
            count_q  <= '0;
            err_q    <= 1'b0;
            order_q  <= '0;
            times_q  <= '0;
        end else if (start) begin
            mask_q   <= phase_off;
            period_q <= period;
            count_q  <= dec_count;
            err_q    <= dec_bad;
            order_q  <= dec_order;
            times_q  <= dec_times;
        end
    end

    // Flag each slot whose time matches the running count.
    for (genvar s = 0; s < NPH; s++) begin : g_hit
        assign slot_hit[s] = run_q && !err_q && (3'(s) < count_q)
                             && (cnt == times_q[s]);
    end

    // Route slot hits to their phase trigger bits.
    always_comb begin
        trig = '0;
        for (int s = 0; s < NPH; s++) begin
            if (slot_hit[s]) trig[order_q[s]] = 1'b1;
        end
    end

    assign active_cnt = count_q;
    assign cfg_err    = err_q;
endmodule

// File: rtl/phase_sequencer_chk.sv
// Checker for phase_sequencer: cycle-by-cycle properties that hold in
// every mode. Attached by the bind below; reads the captured mask.
module phase_sequencer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en,
    input logic [5:0] trig,
    input logic [2:0] active_cnt,
    input logic       cfg_err,
    input logic [5:0] lat_mask
);
    assert_single_trig_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(trig));

    assert_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (trig != 6'd0) |=> ((trig & $past(trig)) == 6'd0));

    assert_err_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (trig == 6'd0 && active_cnt == 3'd0));

    assert_stop_on_disable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (trig == 6'd0));

    assert_off_phase_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (trig & lat_mask) == 6'd0);

    assert_count_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (active_cnt == 3'd0) || (active_cnt >= 3'd3 && active_cnt <= 3'd6));
endmodule

bind phase_sequencer phase_sequencer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .trig       (trig),
    .active_cnt (active_cnt),
    .cfg_err    (cfg_err),
    .lat_mask   (mask_q)
);

// File: tb/tb_phase_sequencer.sv
// Scoreboard bench: the driver task queues every expected pulse with its
// cycle offset; the monitor pops and compares each pulse it observes.
module tb_phase_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int PER_W      = 16;

    typedef struct {
        int         rel;
        logic [5:0] vec;
        string      req;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en = 1'b0;
    logic [PER_W-1:0] period = 16'd6;
    logic [5:0]       phase_off = 6'd0;
    logic [5:0]       trig;
    logic [2:0]       active_cnt;
    logic             cfg_err;

    exp_t exp_q[$];
    int   total = 0;
    int   bad   = 0;
    int   negcount = 0;
    int   base = 0;

    phase_sequencer #(.PER_W(PER_W)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .period     (period),
        .phase_off  (phase_off),
        .trig       (trig),
        .active_cnt (active_cnt),
        .cfg_err    (cfg_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int expv, input string what);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Independent model of the legal sets: phase numbers (1-based) in order.
    function automatic int model(input logic [5:0] m, output int ord[6]);
        for (int i = 0; i < 6; i++) ord[i] = 0;
        case (m)
            6'b000000: begin ord = '{1,2,3,4,5,6}; return 6; end
            6'b000100: begin ord = '{1,2,4,5,6,0}; return 5; end
            6'b100000: begin ord = '{1,2,3,4,5,0}; return 5; end
            6'b100100: begin ord = '{1,2,4,5,0,0}; return 4; end
            6'b010101: begin ord = '{2,4,6,0,0,0}; return 3; end
            default:   return 0;
        endcase
    endfunction

    // Monitor: every observed pulse must match the head of the queue.
    always @(negedge clk) begin
        negcount++;
        if (rst_n && trig !== 6'd0) begin
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R9 unexpected pulse: actual=%b expected=000000 rel=%0d",
                         trig, negcount - base);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.req, int'(trig), int'(e.vec), "pulse phase");
                check(e.req, negcount - base, e.rel, "pulse cycle");
            end
        end
    end

    // Driver: queue expected pulses, run en for runlen cycles, then verify.
    task automatic run_case(input string req, input logic [5:0] m, input int p,
                            input int runlen, input bit disturb);
        int ord[6];
        int n;
        n = model(m, ord);
        for (int r = 0; r < runlen; r++) begin
            for (int k = 0; k < n; k++) begin
                if (r % p == (k * p) / n) begin
                    exp_t e;
                    e.rel = r;
                    e.vec = 6'(1 << (ord[k] - 1));
                    e.req = req;
                    exp_q.push_back(e);
                end
            end
        end
        @(posedge clk); #1;
        phase_off = m;
        period    = PER_W'(p);
        en        = 1'b1;
        base      = negcount + 2;
        if (disturb) begin
            repeat (5) @(posedge clk);
            #1;
            phase_off = 6'b100100;   // R7: must be ignored mid-run
            period    = 16'd10;
            repeat (runlen - 5) @(posedge clk);
        end else begin
            repeat (runlen) @(posedge clk);
        end
        #1 en = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        check(req, exp_q.size(), 0, "missing pulses");
        check("R11", int'(active_cnt), n, "active_cnt");
        check("R8", int'(cfg_err), (n == 0) ? 1 : 0, "cfg_err");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", int'(trig), 0, "reset trig");
        check("R1", int'(active_cnt), 0, "reset active_cnt");
        check("R1", int'(cfg_err), 0, "reset cfg_err");
        @(posedge clk); #1 rst_n = 1'b1;

        run_case("R2", 6'b000000, 61, 122, 1'b0);
        run_case("R3", 6'b000100, 61, 122, 1'b0);
        run_case("R4", 6'b100000, 50, 100, 1'b0);
        run_case("R5", 6'b100100, 23, 46, 1'b0);
        run_case("R6", 6'b010101, 31, 62, 1'b0);
        run_case("R7", 6'b000000, 40, 80, 1'b1);
        run_case("R8", 6'b000011, 30, 60, 1'b0);
        run_case("R8", 6'b001000, 30, 60, 1'b0);
        run_case("R10", 6'b000000, 60, 35, 1'b0);
        run_case("R10", 6'b000000, 12, 24, 1'b0);
        run_case("R9", 6'b000000, 6, 18, 1'b0);
        run_case("R9", 6'b010101, 7, 21, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule